// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single down-counter behind a small APB-style register port. Software programs a reload value, then sets an enable bit and, if it wants an interrupt line, an interrupt-enable bit. Each clock cycle in which the enable bit is set and the external tick strobe is high, the counter steps down by one. The step that takes the count from one to zero raises a sticky status flag. The next qualified tick restores the count from the reload register.

The tick strobe comes from a divider elsewhere in the system and lasts one clock cycle. The status flag stays set until software writes a one to it. The interrupt output is a level that follows the flag, gated by the interrupt-enable bit. The register port writes on the access phase (select and enable both high with write high). Reads return data combinationally while select is high and write is low.

Top module: `apb_dcount_timer`

## Requirements
- R1: After reset, the control, count, reload and status registers all read 0, and `irq_o` is low.
- R2: Register offsets are 0x0 control, 0x4 count, 0x8 reload and 0xC status. In the control register, bit 0 is count enable and bit 3 is interrupt enable. The other control bits are not stored and read as 0. The status flag is bit 0 of the status register.
- R3: On each clock edge where the enable bit is set, `tick_i` is high and the count is non-zero, the count drops by exactly one.
- R4: The count holds its value when the enable bit is clear, or when `tick_i` is low, unless a register write loads it.
- R5: The tick that moves the count from 1 to 0 sets the status flag at the same edge. Right after that tick, the count reads 0 and the status reads 1.
- R6: A qualified tick while the count is 0 loads the count from the reload register. The status flag is not touched by this tick.
- R7: A write to the reload register stores the value and also loads it into the count. A write to the count register loads only the count. A load takes priority over a tick at the same edge.
- R8: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged. If a set and a clear fall on the same edge, the set wins.
- R9: `irq_o` is high exactly when the status flag and the interrupt-enable bit are both 1. If the interrupt-enable bit is clear, the flag can be set while `irq_o` stays low.
- R10: A read of an address outside the four registers returns 0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data; 0 when no read is active |
| tick_i | input | 1 | Single-cycle count strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `tick_i` and the port signals are stable and defined at each rising clock edge, and that a transfer keeps its address and data constant from its setup cycle through its access cycle. The bench drives every input on the falling edge, so these hold. It holds `tick_i` low during ordinary transfers, so that tick timing and write timing can be judged separately. It then brings them together deliberately in one transfer, where a status clear and a zero-crossing tick land on the same edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CTRL   = 32'h0;
  localparam int unsigned OFF_COUNT  = 32'h4;
  localparam int unsigned OFF_RELOAD = 32'h8;
  localparam int unsigned OFF_STATUS = 32'hC;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_IE_BIT = 3;
  localparam int unsigned STAT_FLAG_BIT = 0;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_CTRL,
    RSEL_COUNT,
    RSEL_RELOAD,
    RSEL_STATUS
  } reg_sel_e;

  // One counting step: hold, decrement, or wrap to the reload value.
  function automatic logic [31:0] step_count(input logic [31:0] cur,
                                             input logic [31:0] rld,
                                             input logic        step);
    if (!step)           return cur;
    else if (cur == '0)  return rld;
    else                 return cur - 32'd1;
  endfunction

  // True on the step that lands the count on zero.
  function automatic logic hits_zero(input logic [31:0] cur,
                                     input logic        step);
    return step && (cur == 32'd1);
  endfunction
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] count_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] prdata,
  output logic              ctrl_en,
  output logic              ctrl_ie,
  output logic [DATA_W-1:0] reload_q,
  output logic              wr_count,
  output logic              wr_reload,
  output logic              stat_clr
);
  reg_sel_e sel;
  logic     wr_acc;
  logic     rd_acc;

  always_comb begin
    if      (paddr == ADDR_W'(OFF_CTRL))   sel = RSEL_CTRL;
    else if (paddr == ADDR_W'(OFF_COUNT))  sel = RSEL_COUNT;
    else if (paddr == ADDR_W'(OFF_RELOAD)) sel = RSEL_RELOAD;
    else if (paddr == ADDR_W'(OFF_STATUS)) sel = RSEL_STATUS;
    else                                   sel = RSEL_NONE;
  end

  assign wr_acc    = psel && penable && pwrite;
  assign rd_acc    = psel && !pwrite;
  assign wr_count  = wr_acc && (sel == RSEL_COUNT);
  assign wr_reload = wr_acc && (sel == RSEL_RELOAD);
  assign stat_clr  = wr_acc && (sel == RSEL_STATUS) && pwdata[STAT_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_ie  <= 1'b0;
      reload_q <= '0;
    end else if (wr_acc) begin
      if (sel == RSEL_CTRL) begin
        ctrl_en <= pwdata[CTRL_EN_BIT];
        ctrl_ie <= pwdata[CTRL_IE_BIT];
      end
      if (sel == RSEL_RELOAD) reload_q <= pwdata;
    end
  end

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      case (sel)
        RSEL_CTRL: begin
          prdata[CTRL_EN_BIT] = ctrl_en;
          prdata[CTRL_IE_BIT] = ctrl_ie;
        end
        RSEL_COUNT:  prdata = count_i;
        RSEL_RELOAD: prdata = reload_q;
        RSEL_STATUS: prdata[STAT_FLAG_BIT] = flag_i;
        default:     prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count_q,
  output logic             zero_evt
);
  logic step;
  logic [31:0] nxt;

  assign step     = en && tick && !load;
  assign zero_evt = hits_zero(32'(count_q), step);
  assign nxt      = step_count(32'(count_q), 32'(reload), step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (load)  count_q <= load_val;
    else            count_q <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/apb_dcount_timer.sv
module apb_dcount_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              tick_i,
  output logic              irq_o
);
  logic              ctrl_en;
  logic              ctrl_ie;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count_q;
  logic              wr_count;
  logic              wr_reload;
  logic              stat_clr;
  logic              cnt_load;
  logic              zero_evt;
  logic              status_q;

  assign cnt_load = wr_count || wr_reload;

  tmr_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .count_i(count_q), .flag_i(status_q),
    .prdata(prdata), .ctrl_en(ctrl_en), .ctrl_ie(ctrl_ie), .reload_q(reload_q),
    .wr_count(wr_count), .wr_reload(wr_reload), .stat_clr(stat_clr)
  );

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick_i), .load(cnt_load),
    .load_val(pwdata), .reload(reload_q), .count_q(count_q), .zero_evt(zero_evt)
  );

  tmr_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(zero_evt), .clr_i(stat_clr), .flag_q(status_q)
  );

  assign irq_o = status_q && ctrl_ie;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              ie,
  input logic              tick,
  input logic              load,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] rld,
  input logic              zero_evt,
  input logic              flag,
  input logic              clr,
  input logic              irq
);
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && tick) && !load) |=> $stable(cnt));

  a_r5_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (flag && cnt == '0));

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !load && cnt == '0) |=> cnt == $past(rld));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !zero_evt) |=> !flag);

  a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);
endmodule

bind apb_dcount_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .ie(ctrl_ie), .tick(tick_i),
  .load(cnt_load), .cnt(count_q), .rld(reload_q), .zero_evt(zero_evt),
  .flag(status_q), .clr(stat_clr), .irq(irq_o)
);

// File: tb/tb_apb_dcount_timer.sv
`timescale 1ns/1ps
module tb_apb_dcount_timer;
  localparam int DW = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic          tick_i = 1'b0;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  apb_dcount_timer #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tick_i(tick_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit with_tick = 1'b0);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1; tick_i = with_tick;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #2 d = prdata;
    @(negedge clk);
    psel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
    end
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd("R1 ctrl", 12'h0, 0);
    chk_rd("R1 count", 12'h4, 0);
    chk_rd("R1 reload", 12'h8, 0);
    chk_rd("R1 status", 12'hC, 0);
    check("R1 irq", irq_o, 0);

    // R7 reload write also loads count
    wr(12'h8, 1000);
    chk_rd("R7 count after reload write", 12'h4, 1000);
    chk_rd("R7 reload", 12'h8, 1000);
    wr(12'h0, 9);
    chk_rd("R2 ctrl readback", 12'h0, 9);

    // R3 main run
    ticks(500);
    chk_rd("R3 count half", 12'h4, 500);
    chk_rd("R5 status not yet", 12'hC, 0);
    ticks(500);
    chk_rd("R5 count zero", 12'h4, 0);
    chk_rd("R5 status set", 12'hC, 1);
    check("R9 irq high", irq_o, 1);
    ticks(1);
    chk_rd("R6 reloaded", 12'h4, 1000);
    chk_rd("R6 status untouched", 12'hC, 1);

    // R8 write-one-to-clear
    wr(12'hC, 0);
    chk_rd("R8 zero write keeps", 12'hC, 1);
    wr(12'hC, 1);
    chk_rd("R8 one write clears", 12'hC, 0);
    check("R9 irq low", irq_o, 0);

    // R2 unused ctrl bits
    wr(12'h0, 32'hFFFF_FFFF);
    chk_rd("R2 unused bits zero", 12'h0, 9);

    // R4 disabled: no counting
    wr(12'h0, 0);
    ticks(10);
    chk_rd("R4 disabled hold", 12'h4, 1000);
    wr(12'h0, 1);
    repeat (20) @(negedge clk);
    chk_rd("R4 no tick hold", 12'h4, 1000);

    // R7 count write only loads count; R9 masked
    wr(12'h4, 3);
    chk_rd("R7 count write", 12'h4, 3);
    chk_rd("R7 reload kept", 12'h8, 1000);
    ticks(3);
    chk_rd("R9 flag set while masked", 12'hC, 1);
    check("R9 irq masked", irq_o, 0);
    wr(12'h0, 9);
    check("R9 irq unmasked", irq_o, 1);
    wr(12'hC, 1);

    // R8 set wins over clear on same edge
    wr(12'h4, 2);
    ticks(1);
    wr(12'hC, 1);
    wr(12'h0, 9);
    chk_rd("R8 pre count", 12'h4, 1);
    wr(12'h0, 1);
    ticks(0);
    begin
      logic [DW-1:0] v;
      wr(12'h4, 1);
      wr(12'h0, 9);
      wr(12'hC, 1, 1'b1);
      rd(12'hC, v);
      check("R8 set wins", v, 1);
      rd(12'h4, v);
      check("R8 count zero", v, 0);
    end
    wr(12'hC, 1);

    // R5/R6 sweep over small reload values
    for (int k = 1; k <= 6; k++) begin
      wr(12'h8, k);
      wr(12'hC, 1);
      if (k > 1) begin
        ticks(k - 1);
        chk_rd("R3 sweep one left", 12'h4, 1);
        chk_rd("R5 sweep no flag", 12'hC, 0);
      end
      ticks(1);
      chk_rd("R5 sweep zero", 12'h4, 0);
      chk_rd("R5 sweep flag", 12'hC, 1);
      ticks(1);
      chk_rd("R6 sweep reload", 12'h4, k);
    end

    // R10 unmapped address
    wr(12'h0, 0);
    chk_rd("R10 unmapped read", 12'h10, 0);
    wr(12'h10, 32'h1234);
    wr(12'h18, 32'h9);
    chk_rd("R10 count kept", 12'h4, 6);
    chk_rd("R10 reload kept", 12'h8, 6);
    chk_rd("R10 ctrl kept", 12'h0, 0);
    chk_rd("R10 status kept", 12'hC, 1);

    done = 1'b1;
    finish_run();
  end
endmodule